// File: doc/BRIEF.md
# Serial Gain Word Receiver

This block is the digital control front end of a programmable-gain amplifier. A host writes a 7-bit control word over a three-wire bus made of an active-low chip-select, a serial clock and a data line. The word carries a 6-bit gain code and one software sleep bit. The block keeps the applied setting in a latch. The latch updates only when a frame of exactly seven bits closes, so the gain never moves while a new word is being shifted in.

All three bus lines are brought into the system clock domain through two-flop synchronizers. Edges are then detected on the synchronized copies, so the system clock must run at least four times faster than the serial clock. A hardware shutdown input and a transmit-enable input are sampled on the system clock and combine with the sleep bit to form the signal-path enable. Shutdown also wipes all stored gain state. There is no streaming data path: every pin is a plain control or status level.

Top module: `gcw_receiver`

## Requirements
- R1: After reset the block reports gain_code 0, sleep 1 and path_en 0.
- R2: Data is taken least significant bit first, one bit per rising edge of the serial clock while chip-select is low. When chip-select rises after seven bits, gain_code becomes bits 5..0 of the word (bit 0 first on the wire) and sleep becomes the inverse of bit 6.
- R3: While a frame is being shifted, gain_code and sleep keep their previous values, up to the rise of chip-select.
- R4: If chip-select rises after any bit count other than seven (zero, six or eight, for example), the frame is dropped and the latched word is unchanged.
- R5: A received gain field above 58 is latched as 58. gain_code never exceeds 58.
- R6: Serial clock edges while chip-select is high shift nothing and do not alter the latched word.
- R7: While shdn_n is low, the shift state and the latch clear (gain_code 0, sleep 1) and path_en is 0. A frame in progress is discarded. After release the block stays at gain 0 and asleep until a full new word arrives. Shutdown takes priority over a frame that closes in the same cycle.
- R8: path_en is high only when tx_en is high, shdn_n is high and sleep is 0. With tx_en low the bus still accepts words and the latched word is kept.
- R9: A latched bit 6 of 0 puts the block to sleep (path_en 0), and a 1 wakes it. Words are still accepted while asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low power-on reset, clears all state |
| shdn_n | input | 1 | Active-low hardware shutdown, sampled on clk |
| tx_en | input | 1 | Transmit enable for the signal path |
| bus_csn | input | 1 | Serial chip-select, active low |
| bus_sck | input | 1 | Serial clock |
| bus_sdi | input | 1 | Serial data |
| gain_code | output | 6 | Applied gain code, 0 to 58 |
| sleep | output | 1 | Software sleep state (inverse of latched bit 6) |
| path_en | output | 1 | Combined signal-path enable |

## Verification
Two functions can fall in the same cycle: the latch update caused by a completed frame, and the clear caused by hardware shutdown. The bench shifts a full seven-bit word, then drops shdn_n before raising chip-select and holds it low through the whole window in which the chip-select rise is recognised. It then expects gain 0 and sleep 1 after release. A second case pulls shutdown in the middle of a frame and then completes the bit count, and expects the frame to be lost.

// File: rtl/gcw_pkg.sv
package gcw_pkg;
  localparam int unsigned WORD_BITS  = 7;
  localparam int unsigned GAIN_BITS  = WORD_BITS - 1;
  localparam int unsigned GAIN_LIMIT = 58;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/gcw_sync.sv
module gcw_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= IDLE;
      else if (s == 0) stage_q[s] <= d_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gcw_shifter.sv
module gcw_shifter #(
  parameter int unsigned WORD_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 csn_s,
  input  logic                 sck_s,
  input  logic                 sdi_s,
  output logic                 load,
  output logic [WORD_BITS-1:0] word
);
  localparam int unsigned CNT_W = $clog2(WORD_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_BITS + 1);

  logic                 csn_prev, sck_prev, active_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [WORD_BITS-1:0] sr_q;
  logic                 csn_fall, csn_rise, sck_rise;

  assign csn_fall = csn_prev & ~csn_s;
  assign csn_rise = ~csn_prev & csn_s;
  assign sck_rise = ~sck_prev & sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_prev <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      csn_prev <= csn_s;
      sck_prev <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
      load     <= 1'b0;
    end else if (clr) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
      load     <= 1'b0;
    end else begin
      load <= 1'b0;
      if (csn_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (csn_rise) begin
        active_q <= 1'b0;
        load     <= active_q && (cnt_q == CNT_FULL);
      end else if (active_q && sck_rise) begin
        sr_q <= {sdi_s, sr_q[WORD_BITS-1:1]};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word = sr_q;

  AST_LOAD_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> $past(cnt_q) == CNT_FULL); // R4
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !clr) |=> $stable(sr_q)); // R6
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_OVER); // R4
endmodule

// File: rtl/gcw_latch.sv
module gcw_latch #(
  parameter int unsigned WORD_BITS  = 7,
  parameter int unsigned GAIN_LIMIT = 58
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] word_in,
  output logic [WORD_BITS-2:0] gain_q,
  output logic                 awake_q
);
  localparam int unsigned GW = WORD_BITS - 1;
  localparam logic [GW-1:0] LIMIT = GW'(GAIN_LIMIT);

  logic [GW-1:0] gain_in;
  assign gain_in = (word_in[GW-1:0] > LIMIT) ? LIMIT : word_in[GW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q  <= '0;
      awake_q <= 1'b0;
    end else if (clr) begin
      gain_q  <= '0;
      awake_q <= 1'b0;
    end else if (load) begin
      gain_q  <= gain_in;
      awake_q <= word_in[WORD_BITS-1];
    end
  end

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= LIMIT); // R5
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> $stable({awake_q, gain_q})); // R3
  AST_SHDN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (gain_q == '0) && !awake_q); // R7
endmodule

// File: rtl/gcw_receiver.sv
module gcw_receiver #(
  parameter int unsigned WORD_BITS  = gcw_pkg::WORD_BITS,
  parameter int unsigned GAIN_LIMIT = gcw_pkg::GAIN_LIMIT,
  parameter int unsigned SYNC_DEPTH = gcw_pkg::SYNC_DEPTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shdn_n,
  input  logic                 tx_en,
  input  logic                 bus_csn,
  input  logic                 bus_sck,
  input  logic                 bus_sdi,
  output logic [WORD_BITS-2:0] gain_code,
  output logic                 sleep,
  output logic                 path_en
);
  logic [2:0]           bus_s;
  logic                 load, awake, clr;
  logic [WORD_BITS-1:0] word;

  assign clr = ~shdn_n;

  gcw_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH), .IDLE(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({bus_csn, bus_sck, bus_sdi}), .d_out(bus_s)
  );

  gcw_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .csn_s(bus_s[2]), .sck_s(bus_s[1]), .sdi_s(bus_s[0]),
    .load(load), .word(word)
  );

  gcw_latch #(.WORD_BITS(WORD_BITS), .GAIN_LIMIT(GAIN_LIMIT)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load),
    .word_in(word), .gain_q(gain_code), .awake_q(awake)
  );

  assign sleep   = ~awake;
  assign path_en = tx_en & shdn_n & awake;

  AST_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !path_en); // R8
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !path_en); // R9
endmodule

// File: tb/gcw_receiver_test.sv
module gcw_receiver_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn_n = 1'b1, tx_en = 1'b1;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [5:0] gain_code;
  logic sleep, path_en;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gcw_receiver uut (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .tx_en(tx_en),
    .bus_csn(csn), .bus_sck(sck), .bus_sdi(sdi),
    .gain_code(gain_code), .sleep(sleep), .path_en(path_en)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic expect_state(input string req, input int g, input int s, input int p);
    @(negedge clk);
    check({req, " gain"}, gain_code, g);
    check({req, " sleep"}, sleep, s);
    check({req, " path"}, path_en, p);
  endtask

  task automatic frame_start;
    csn = 1'b0;
    tick(4);
  endtask

  task automatic shift_bits(input logic [7:0] w, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      sdi = w[i];
      tick(4);
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
    end
  endtask

  task automatic frame_end;
    tick(4);
    csn = 1'b1;
    tick(10);
  endtask

  task automatic send(input logic [7:0] w, input int n);
    frame_start;
    shift_bits(w, 0, n);
    frame_end;
  endtask

  task automatic t_reset;
    expect_state("R1 reset", 0, 1, 0);
  endtask

  task automatic t_basic;
    send(8'h65, 7);
    expect_state("R2 word 0x65", 37, 0, 1);
    send(8'h4B, 7);
    expect_state("R2 word 0x4B", 11, 0, 1);
  endtask

  task automatic t_hold;
    frame_start;
    shift_bits(8'h50, 0, 4);
    expect_state("R3 mid frame", 11, 0, 1);
    shift_bits(8'h50, 4, 3);
    tick(4);
    expect_state("R3 before cs rise", 11, 0, 1);
    csn = 1'b1;
    tick(10);
    expect_state("R3 after cs rise", 16, 0, 1);
  endtask

  task automatic t_badcount;
    send(8'h7F, 6);
    expect_state("R4 six bits", 16, 0, 1);
    send(8'hFF, 8);
    expect_state("R4 eight bits", 16, 0, 1);
    send(8'h00, 0);
    expect_state("R4 zero bits", 16, 0, 1);
  endtask

  task automatic t_clamp;
    send(8'h7F, 7);
    expect_state("R5 clamp awake", 58, 0, 1);
    send(8'h3B, 7);
    expect_state("R5 R9 clamp asleep", 58, 1, 0);
  endtask

  task automatic t_sleep_bus;
    send(8'h45, 7);
    expect_state("R9 wake via bus", 5, 0, 1);
  endtask

  task automatic t_idle_sck;
    sdi = 1'b1;
    for (int i = 0; i < 7; i++) begin
      tick(4); sck = 1'b1; tick(4); sck = 1'b0;
    end
    tick(10);
    expect_state("R6 clocks with cs high", 5, 0, 1);
  endtask

  task automatic t_txen;
    tx_en = 1'b0;
    tick(1);
    expect_state("R8 tx off", 5, 0, 0);
    send(8'h4A, 7);
    expect_state("R8 load with tx off", 10, 0, 0);
    tx_en = 1'b1;
    tick(1);
    expect_state("R8 tx on", 10, 0, 1);
  endtask

  task automatic t_shdn;
    shdn_n = 1'b0;
    tick(3);
    expect_state("R7 in shutdown", 0, 1, 0);
    shdn_n = 1'b1;
    tick(3);
    expect_state("R7 after release", 0, 1, 0);
    send(8'h60, 7);
    expect_state("R7 resend", 32, 0, 1);
  endtask

  task automatic t_shdn_midframe;
    frame_start;
    shift_bits(8'h7F, 0, 3);
    shdn_n = 1'b0;
    tick(4);
    shdn_n = 1'b1;
    shift_bits(8'h7F, 3, 4);
    frame_end;
    expect_state("R7 mid frame shutdown", 0, 1, 0);
  endtask

  task automatic t_collide;
    send(8'h45, 7);
    expect_state("R2 before collision", 5, 0, 1);
    frame_start;
    shift_bits(8'h55, 0, 7);
    tick(4);
    shdn_n = 1'b0;
    csn = 1'b1;
    tick(12);
    shdn_n = 1'b1;
    tick(4);
    expect_state("R7 shutdown beats frame close", 0, 1, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset;
    t_basic;
    t_hold;
    t_badcount;
    t_clamp;
    t_sleep_bus;
    t_idle_sck;
    t_txen;
    t_shdn;
    t_shdn_midframe;
    t_collide;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule